// File: doc/BRIEF.md
# Sync-Aligned Decimate-by-Two Front End

This block sits at the input of a sample datapath. It either forwards every sample it receives or keeps only every second one. Each input beat carries a set of candidate sync lines as sideband. A source-select register picks which of these lines is used. In decimate-by-two mode, a pulse on the chosen line marks the sample that must be kept. This fixes the phase of the decimator from outside, instead of leaving it to reset. A small control interface writes the mode register and the sync source register. The mode register can also be read back.

Both streaming sides use valid/ready handshakes, and the output is a single register stage. A beat transfers on the input only when `s_valid` and `s_ready` are both high. `s_ready` is high whenever the output register is empty or is being emptied in the same cycle (`!m_valid || m_ready`). While `m_valid` is high and `m_ready` is low, the output holds its data steady and no new beat is accepted. Sync lines are looked at only on beats that transfer. A dropped sample still counts as an accepted input beat, but it produces no output.

Top module: `dec2_front`

## Requirements
- R1: After reset the mode register reads 0x0001, the source selector is 0, `m_valid` is 0 and `s_ready` is 1.
- R2: A mode write stores only bits [1:0] of `mode_wdata`. `mode_rdata` then returns those two bits, with bits [15:2] reading as zero.
- R3: With mode bits 01, 00 or 11 (pass-through), every accepted beat appears on the output one cycle later, in order and unchanged.
- R4: With mode bits 10 (decimate by two) and no sync pulses, accepted beats are kept and dropped alternately, and the kept beats keep their order.
- R5: In decimate mode, an accepted beat whose selected sync line is high is always kept. The next accepted beat without a sync pulse is dropped.
- R6: The phase toggle resets to "keep" and advances only on accepted beats in decimate mode. After reset, the first beat accepted in decimate mode is kept.
- R7: Only the sync line indexed by the selector register has any effect. Pulses on the other lines do not change which beats are kept.
- R8: In pass-through mode, sync pulses have no effect: every beat passes, and the phase toggle is left unchanged for later decimate traffic.
- R9: `s_ready` equals `!m_valid || m_ready`. While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` stays stable. Beats that do not transfer do not advance the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample ready |
| s_data | input | DATA_W | Input sample |
| s_sync | input | NUM_SYNC | Candidate sync lines, sideband of the input beat |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Output sample ready |
| m_data | output | DATA_W | Retained sample |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 16 | Mode register write data, bits [1:0] used |
| mode_rdata | output | 16 | Mode register read-back |
| srcsel_we | input | 1 | Sync source selector write strobe |
| srcsel_wdata | input | SEL_W | Sync source selector write data |

## Verification
Directed sequences check several cases that a wrong design would get wrong. With no sync after reset, the keep/drop pattern must start on "keep", which exposes a toggle that starts in the wrong phase. A sync placed on a beat that would otherwise be dropped must pull that beat into the output, which separates a sync-forced phase from a free-running one. A pulse on a line that is not selected must leave the pattern alone, which exposes a selector that is ignored. Random traffic in all four mode codes adds random sync pulses, random stalls on both sides and random gaps in valid. A bench model of the phase checks this traffic and shows whether the phase advances only on beats that actually transfer.

// File: rtl/dec2_pkg.sv
package dec2_pkg;
  localparam int unsigned REG_W = 16;
  localparam logic [REG_W-1:0] MODE_RST = 16'h0001;

  typedef enum logic [1:0] {
    MODE_IDLE0 = 2'b00,
    MODE_PASS  = 2'b01,
    MODE_DEC2  = 2'b10,
    MODE_IDLE3 = 2'b11
  } mode_e;

  function automatic logic is_dec2(input logic [1:0] code);
    return code == MODE_DEC2;
  endfunction
endpackage

// File: rtl/dec2_ctrl_regs.sv
module dec2_ctrl_regs
  import dec2_pkg::*;
#(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_we,
  input  logic [REG_W-1:0] mode_wdata,
  input  logic             sel_we,
  input  logic [SEL_W-1:0] sel_wdata,
  output logic [1:0]       mode_code,
  output logic [SEL_W-1:0] sel_q,
  output logic [REG_W-1:0] mode_rd
);
  logic [1:0] mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_RST[1:0];
      sel_q  <= '0;
    end else begin
      if (mode_we) mode_q <= mode_wdata[1:0];
      if (sel_we)  sel_q  <= sel_wdata;
    end
  end

  assign mode_code = mode_q;
  assign mode_rd   = {{(REG_W-2){1'b0}}, mode_q};

  // R2: written field reads back, reserved bits zero
  p_mode_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> mode_rd == {{(REG_W-2){1'b0}}, $past(mode_wdata[1:0])});
endmodule

// File: rtl/dec2_sync_pick.sv
module dec2_sync_pick #(
  parameter int unsigned NUM_SYNC = 4,
  parameter int unsigned SEL_W    = 2
) (
  input  logic [NUM_SYNC-1:0] sync_in,
  input  logic [SEL_W-1:0]    sel,
  output logic                sync_hit
);
  logic [NUM_SYNC-1:0] hits;

  for (genvar i = 0; i < NUM_SYNC; i++) begin : g_line
    assign hits[i] = sync_in[i] && (sel == SEL_W'(i));
  end

  assign sync_hit = |hits;
endmodule

// File: rtl/dec2_phase.sv
module dec2_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic dec_en,
  input  logic sync_hit,
  output logic keep
);
  logic tog;
  logic keep_dec;

  assign keep_dec = sync_hit || tog;
  assign keep     = !dec_en || keep_dec;

  always_ff @(posedge clk) begin
    if (!rst_n)               tog <= 1'b1;
    else if (beat && dec_en)  tog <= !keep_dec;
  end

  // R8: toggle holds on any cycle without a decimate-mode beat
  p_tog_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(beat && dec_en) |=> $stable(tog));
endmodule

// File: rtl/dec2_front.sv
module dec2_front
  import dec2_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_SYNC = 4,
  localparam int unsigned SEL_W   = (NUM_SYNC > 1) ? $clog2(NUM_SYNC) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [DATA_W-1:0]   s_data,
  input  logic [NUM_SYNC-1:0] s_sync,
  output logic                m_valid,
  input  logic                m_ready,
  output logic [DATA_W-1:0]   m_data,
  input  logic                mode_we,
  input  logic [REG_W-1:0]    mode_wdata,
  output logic [REG_W-1:0]    mode_rdata,
  input  logic                srcsel_we,
  input  logic [SEL_W-1:0]    srcsel_wdata
);
  logic [1:0]       mode_code;
  logic [SEL_W-1:0] sel_q;
  logic             sync_hit;
  logic             keep;
  logic             beat;
  logic             dec_en;

  dec2_ctrl_regs #(.SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .sel_we(srcsel_we), .sel_wdata(srcsel_wdata),
    .mode_code(mode_code), .sel_q(sel_q), .mode_rd(mode_rdata)
  );

  dec2_sync_pick #(.NUM_SYNC(NUM_SYNC), .SEL_W(SEL_W)) u_pick (
    .sync_in(s_sync), .sel(sel_q), .sync_hit(sync_hit)
  );

  assign dec_en  = is_dec2(mode_code);
  assign s_ready = !m_valid || m_ready;
  assign beat    = s_valid && s_ready;

  dec2_phase u_phase (
    .clk(clk), .rst_n(rst_n), .beat(beat),
    .dec_en(dec_en), .sync_hit(sync_hit), .keep(keep)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (beat) begin
      m_valid <= keep;
      if (keep) m_data <= s_data;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  // R9: stalled output holds
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R3: pass-through forwards each accepted beat next cycle
  p_pass_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !dec_en) |=> (m_valid && m_data == $past(s_data)));

  // R5: a selected sync pulse in decimate mode forces the beat out
  p_sync_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && dec_en && sync_hit) |=> (m_valid && m_data == $past(s_data)));
endmodule

// File: tb/dec2_front_tb.sv
module dec2_front_tb;
  localparam int DW = 16;
  localparam int NS = 4;
  localparam int SW = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic s_valid = 0, s_ready, m_valid, m_ready = 0;
  logic [DW-1:0] s_data = '0, m_data;
  logic [NS-1:0] s_sync = '0;
  logic mode_we = 0, srcsel_we = 0;
  logic [15:0] mode_wdata = '0, mode_rdata;
  logic [SW-1:0] srcsel_wdata = '0;

  always #2 clk = ~clk;

  dec2_front #(.DATA_W(DW), .NUM_SYNC(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_sync(s_sync), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .mode_rdata(mode_rdata), .srcsel_we(srcsel_we), .srcsel_wdata(srcsel_wdata)
  );

  int checks = 0, errors = 0;
  logic [DW-1:0] q[$];
  bit mtog = 1;
  logic [1:0] mmode = 2'b01;
  int msel = 0;
  string tag = "R3";
  bit stall_pend = 0;
  logic [DW-1:0] stall_data;
  bit done = 0;

  task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", t, act, exp);
    end
  endtask

  function automatic bit model_keep(input logic [1:0] md, input bit hit, input bit tg);
    if (md != 2'b10) return 1'b1;
    return hit || tg;
  endfunction

  // evaluate ports after inputs settle, before the next rising edge
  task automatic evaluate();
    chk(s_ready == (!m_valid || m_ready), "R9", s_ready, !m_valid || m_ready);
    if (stall_pend) begin
      chk(m_valid && m_data == stall_data, "R9", m_data, stall_data);
      stall_pend = 0;
    end
    if (m_valid && m_ready) begin
      if (q.size() == 0) chk(0, tag, m_data, 32'hDEAD);
      else begin
        logic [DW-1:0] e;
        e = q.pop_front();
        chk(m_data == e, tag, m_data, e);
      end
    end else if (m_valid) begin
      stall_pend = 1;
      stall_data = m_data;
    end
    if (s_valid && s_ready) begin
      bit k;
      bit hit;
      hit = s_sync[msel];
      k = model_keep(mmode, hit, mtog);
      if (mmode == 2'b10) mtog = !k;
      if (k) q.push_back(s_data);
    end
  endtask

  task automatic rnd_cycle(input int pv, input int pr, input int ps);
    @(negedge clk);
    s_valid = ($urandom % 100) < pv;
    s_data  = DW'($urandom);
    m_ready = ($urandom % 100) < pr;
    s_sync  = (($urandom % 100) < ps) ? NS'($urandom) : '0;
    #1 evaluate();
  endtask

  task automatic beat(input logic [DW-1:0] d, input logic [NS-1:0] sy);
    @(negedge clk);
    s_valid = 1; s_data = d; m_ready = 1; s_sync = sy;
    #1 evaluate();
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      s_valid = 0; s_sync = '0; m_ready = 1;
      #1 evaluate();
    end
    chk(q.size() == 0, tag, q.size(), 0);
  endtask

  task automatic wr_mode(input logic [15:0] v);
    drain();
    @(negedge clk);
    mode_we = 1; mode_wdata = v;
    #1 evaluate();
    @(negedge clk);
    mode_we = 0;
    mmode = v[1:0];
    #1 evaluate();
    chk(mode_rdata == {14'b0, v[1:0]}, "R2", mode_rdata, {14'b0, v[1:0]});
  endtask

  task automatic wr_sel(input int s);
    @(negedge clk);
    srcsel_we = 1; srcsel_wdata = SW'(s);
    @(negedge clk);
    srcsel_we = 0;
    msel = s;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(mode_rdata == 16'h0001, "R1", mode_rdata, 16'h0001);
    chk(m_valid == 0, "R1", m_valid, 0);
    chk(s_ready == 1, "R1", s_ready, 1);

    // R6: first decimate beats after reset, no sync
    wr_mode(16'h0002);
    tag = "R6";
    beat(16'h0010, '0); beat(16'h0011, '0); beat(16'h0012, '0); beat(16'h0013, '0);
    drain();
    // R5: sync forces a beat that would be dropped
    tag = "R5";
    beat(16'h0020, '0); beat(16'h0021, 4'b0001); beat(16'h0022, '0); beat(16'h0023, '0);
    drain();
    // R7: non-selected line ignored (selector 2, pulse line 0)
    wr_sel(2);
    tag = "R7";
    beat(16'h0030, 4'b0001); beat(16'h0031, 4'b0001); beat(16'h0032, 4'b0100); beat(16'h0033, 4'b1011);
    drain();
    // R2: reserved bits dropped
    wr_mode(16'hFFFE);
    // R8: sync in pass mode; toggle must be unchanged afterwards
    wr_mode(16'h0001);
    tag = "R8";
    for (int i = 0; i < 6; i++) beat(DW'(16'h0040 + i), 4'b1111);
    wr_mode(16'h0002);
    beat(16'h0050, '0); beat(16'h0051, '0);
    drain();

    // random traffic across all mode codes
    for (int m = 0; m < 4; m++) begin
      wr_mode({14'b0, 2'(m)});
      wr_sel(m);
      tag = (m == 2) ? "R4" : "R3";
      for (int i = 0; i < 600; i++) rnd_cycle(70, 60, 20);
      drain();
    end
    tag = "R4";
    wr_mode(16'h0002);
    for (int i = 0; i < 400; i++) rnd_cycle(80, 50, 0);
    drain();
    tag = "R9";
    for (int i = 0; i < 400; i++) rnd_cycle(90, 20, 30);
    drain();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule